// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

A single-port synchronous static RAM whose write data trails its write command by one clock. On each rising edge the block captures a chip select, a write enable, an address and a set of byte-lane write enables. The data for a write is sampled on the next rising edge. It is then parked in a one-entry write buffer together with the captured address and lane mask, and it is committed to the array on the edge after that. A read that targets the parked address gets the buffered lanes merged over the array word, so the buffer cannot be seen from outside.

Read data leaves through an output register. The output drivers are modelled as a data bus plus a separate drive-enable. That enable is gated combinationally by an asynchronous output enable. The word is built from 9-bit lanes. `LANES` and `ADDR_W` select the shape: `LANES=2, ADDR_W=16` gives 64K x 18, and `LANES=4, ADDR_W=15` gives 32K x 36. The defaults are a reduced-depth x18 build.

Top module: `late_write_sram`

## Requirements
- R1: A read captured at rising edge N (`cmd_sel`=1, `cmd_we`=0) presents the addressed word on `dq_out` after edge N+1, and `dq_oe` equals `out_en` from then until the next output-register update.
- R2: For a write captured at edge N, the word written is the `wr_data` sampled at edge N+1; the value on `wr_data` at edge N is ignored.
- R3: Lane i occupies `wr_data`/`dq_out` bits [9i+8:9i], and `cmd_lane_we[i]`=1 writes lane i; lanes whose enable is 0 keep their previous contents, including when the mask is all zeros.
- R4: A read of the address whose write data is still buffered returns the buffered lanes selected by that write's mask and array contents for the other lanes; a read of a different address is unaffected by the buffer.
- R5: Writes may be issued on consecutive cycles at full rate, to different or to the same address, and every one of them lands in order.
- R6: With `cmd_sel`=0 at an edge the cycle is a no-op: nothing is written, and after the following edge `dq_oe` is 0 while `dq_out` holds its previous value.
- R7: After the edge following a write capture, `dq_oe` is 0 and `dq_out` holds its previous value.
- R8: `dq_oe` is 0 whenever `out_en` is 0, and follows `out_en` changes without any clock edge.
- R9: While `rst_n` is 0, `dq_oe` is 0 and `dq_out` is all zeros.
- R10: With `LANES`=4 the block behaves as a 36-bit wide memory under R1 to R8, each of its four lanes independently maskable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all capture on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control and output registers |
| cmd_sel | input | 1 | Synchronous chip select, 1 = cycle active |
| cmd_we | input | 1 | 1 = write command, 0 = read command |
| cmd_addr | input | ADDR_W | Word address |
| cmd_lane_we | input | LANES | Per-lane write enables for a write command |
| wr_data | input | 9*LANES | Write data, sampled one edge after its command |
| out_en | input | 1 | Asynchronous output enable |
| dq_out | output | 9*LANES | Read data from the output register |
| dq_oe | output | 1 | Drive enable for `dq_out`; 0 models high impedance |

## Verification
The assertions watch the control timing on every cycle. A deselect or a write must leave the output register unchanged and undriven two edges later. A read must leave the drive-enable tracking `out_en`, and `dq_oe` may never be high while `out_en` is low. Data correctness can only be shown by the bench's scenarios. That covers late-data sampling, lane masking, the byte-wise merge of buffered data during a read right after a write, back-to-back writes to one address, and the 36-bit build. The bench compares every read against its own reference memory.

// File: rtl/late_sram_pkg.sv
package late_sram_pkg;

    // width of one byte lane including its ninth bit
    localparam int unsigned LANE_W = 9;

    // command held in the capture stage for one cycle
    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } cmd_kind_e;

endpackage

// File: rtl/late_sram_cmd.sv
module late_sram_cmd
    import late_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_we,
    output cmd_kind_e         kind_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [LANES-1:0]  mask_q
);

    typedef struct packed {
        cmd_kind_e         kind;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  mask;
    } cmd_t;

    cmd_t cmd_d, cmd_q;

    always_comb begin
        cmd_d = cmd_q;
        if (!sel) begin
            cmd_d.kind = CMD_IDLE;
        end else if (we) begin
            cmd_d.kind = CMD_WRITE;
            cmd_d.addr = addr;
            cmd_d.mask = lane_we;
        end else begin
            cmd_d.kind = CMD_READ;
            cmd_d.addr = addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '{kind: CMD_IDLE, addr: '0, mask: '0};
        end else begin
            cmd_q <= cmd_d;
        end
    end

    assign kind_q = cmd_q.kind;
    assign addr_q = cmd_q.addr;
    assign mask_q = cmd_q.mask;

endmodule

// File: rtl/late_sram_wbuf.sv
module late_sram_wbuf
    import late_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned LANES  = 2,
    localparam int unsigned DATA_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_kind_e         cmd_kind,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LANES-1:0]  cmd_mask,
    input  logic [DATA_W-1:0] wr_data,
    output logic              buf_vld,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [LANES-1:0]  buf_mask,
    output logic [DATA_W-1:0] buf_data
);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  mask;
        logic [DATA_W-1:0] data;
    } wbuf_t;

    wbuf_t buf_d, buf_q;

    // the entry is refilled every cycle its data arrives; the previous
    // entry is being committed to the array on that same edge
    always_comb begin
        buf_d     = buf_q;
        buf_d.vld = (cmd_kind == CMD_WRITE);
        if (cmd_kind == CMD_WRITE) begin
            buf_d.addr = cmd_addr;
            buf_d.mask = cmd_mask;
            buf_d.data = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '{vld: 1'b0, addr: '0, mask: '0, data: '0};
        end else begin
            buf_q <= buf_d;
        end
    end

    assign buf_vld  = buf_q.vld;
    assign buf_addr = buf_q.addr;
    assign buf_mask = buf_q.mask;
    assign buf_data = buf_q.data;

endmodule

// File: rtl/late_sram_array.sv
module late_sram_array
    import late_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned LANES  = 2,
    localparam int unsigned DATA_W = LANE_W * LANES,
    localparam int unsigned DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANES-1:0]  wr_mask,
    input  logic [DATA_W-1:0] wr_word,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word
);

    // one storage column per lane so each lane has its own write strobe
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[g]) begin
                mem_q[wr_addr] <= wr_word[g*LANE_W +: LANE_W];
            end
        end

        assign rd_word[g*LANE_W +: LANE_W] = mem_q[rd_addr];
    end

endmodule

// File: rtl/late_sram_rdout.sv
module late_sram_rdout
    import late_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned LANES  = 2,
    localparam int unsigned DATA_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_kind_e         cmd_kind,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] arr_word,
    input  logic              buf_vld,
    input  logic [ADDR_W-1:0] buf_addr,
    input  logic [LANES-1:0]  buf_mask,
    input  logic [DATA_W-1:0] buf_data,
    input  logic              out_en,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    typedef struct packed {
        logic              drive;
        logic [DATA_W-1:0] data;
    } rd_t;

    rd_t rd_d, rd_q;

    logic              buf_hit;
    logic [DATA_W-1:0] fwd_word;

    assign buf_hit = buf_vld && (buf_addr == cmd_addr);

    // lane-wise merge of the uncommitted write over the array word
    for (genvar g = 0; g < LANES; g++) begin : g_fwd
        assign fwd_word[g*LANE_W +: LANE_W] = (buf_hit && buf_mask[g])
            ? buf_data[g*LANE_W +: LANE_W]
            : arr_word[g*LANE_W +: LANE_W];
    end

    always_comb begin
        rd_d       = rd_q;
        rd_d.drive = (cmd_kind == CMD_READ);
        if (cmd_kind == CMD_READ) begin
            rd_d.data = fwd_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '{drive: 1'b0, data: '0};
        end else begin
            rd_q <= rd_d;
        end
    end

    assign dq_out = rd_q.data;
    assign dq_oe  = rd_q.drive && out_en;

endmodule

// File: rtl/late_write_sram.sv
module late_write_sram
    import late_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned LANES  = 2,
    localparam int unsigned DATA_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_sel,
    input  logic              cmd_we,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LANES-1:0]  cmd_lane_we,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              out_en,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    cmd_kind_e         c_kind;
    logic [ADDR_W-1:0] c_addr;
    logic [LANES-1:0]  c_mask;
    logic              b_vld;
    logic [ADDR_W-1:0] b_addr;
    logic [LANES-1:0]  b_mask;
    logic [DATA_W-1:0] b_data;
    logic [DATA_W-1:0] a_word;

    late_sram_cmd #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (cmd_sel),
        .we      (cmd_we),
        .addr    (cmd_addr),
        .lane_we (cmd_lane_we),
        .kind_q  (c_kind),
        .addr_q  (c_addr),
        .mask_q  (c_mask)
    );

    late_sram_wbuf #(.ADDR_W(ADDR_W), .LANES(LANES)) u_wbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_kind (c_kind),
        .cmd_addr (c_addr),
        .cmd_mask (c_mask),
        .wr_data  (wr_data),
        .buf_vld  (b_vld),
        .buf_addr (b_addr),
        .buf_mask (b_mask),
        .buf_data (b_data)
    );

    late_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
        .clk     (clk),
        .wr_en   (b_vld),
        .wr_addr (b_addr),
        .wr_mask (b_mask),
        .wr_word (b_data),
        .rd_addr (c_addr),
        .rd_word (a_word)
    );

    late_sram_rdout #(.ADDR_W(ADDR_W), .LANES(LANES)) u_rdout (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_kind (c_kind),
        .cmd_addr (c_addr),
        .arr_word (a_word),
        .buf_vld  (b_vld),
        .buf_addr (b_addr),
        .buf_mask (b_mask),
        .buf_data (b_data),
        .out_en   (out_en),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe)
    );

    // R1
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_sel && !cmd_we) |=> ##1 (dq_oe == out_en));

    // R6
    deselect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_sel |=> ##1 (!dq_oe && $stable(dq_out)));

    // R7
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_sel && cmd_we) |=> ##1 (!dq_oe && $stable(dq_out)));

    // R8
    always_comb begin
        if (!out_en) begin
            oe_gate_chk: assert (!dq_oe);
        end
    end

    // R9
    always_comb begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!dq_oe && dq_out == '0);
        end
    end

endmodule

// File: tb/test_late_write_sram.sv
module test_late_write_sram;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        we = 1'b0;
    logic [5:0]  addr = '0;
    logic [3:0]  mask = '0;
    logic [35:0] wdata = '0;
    logic        oe = 1'b1;

    logic [17:0] dq_a;
    logic        oe_a;
    logic [35:0] dq_b;
    logic        oe_b;

    always #(CLK_PERIOD/2) clk = ~clk;

    late_write_sram #(.ADDR_W(10), .LANES(2)) i_late_write_sram (
        .clk (clk), .rst_n (rst_n), .cmd_sel (sel), .cmd_we (we),
        .cmd_addr ({4'b0, addr}), .cmd_lane_we (mask[1:0]),
        .wr_data (wdata[17:0]), .out_en (oe), .dq_out (dq_a), .dq_oe (oe_a)
    );

    // wide build (R10) driven with the same stimulus
    late_write_sram #(.ADDR_W(6), .LANES(4)) i_late_write_sram_wide (
        .clk (clk), .rst_n (rst_n), .cmd_sel (sel), .cmd_we (we),
        .cmd_addr (addr), .cmd_lane_we (mask),
        .wr_data (wdata), .out_en (oe), .dq_out (dq_b), .dq_oe (oe_b)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [35:0] ref_mem [64];
    logic [35:0] last_val = '0;
    logic        last_drive = 1'b0;
    logic        pend = 1'b0;
    logic [35:0] pend_d = '0;
    // two-deep record of issued commands: 0 idle, 1 read, 2 write
    int          q_kind [2] = '{0, 0};
    logic [35:0] q_val  [2];
    string       q_tag  [2] = '{"R6", "R6"};

    function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] d,
                                          input logic [3:0] m);
        logic [35:0] r = old;
        for (int i = 0; i < 4; i++) if (m[i]) r[i*9 +: 9] = d[i*9 +: 9];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic s, input logic w, input logic [5:0] a,
                        input logic [3:0] m, input logic [35:0] d,
                        input logic o, input string tag);
        @(negedge clk);
        wdata = pend ? pend_d : {$urandom, $urandom} ; // junk off the data cycle (R2)
        sel = s; we = w; addr = a; mask = m; oe = o;
        #1;
        last_drive = (q_kind[1] == 1);
        if (last_drive) last_val = q_val[1];
        chk({q_tag[1], " oe"}, {35'b0, oe_a}, {35'b0, o && last_drive});
        chk({q_tag[1], " data"}, {18'b0, dq_a}, {18'b0, last_val[17:0]});
        chk({q_tag[1], "/R10 oe"}, {35'b0, oe_b}, {35'b0, o && last_drive});
        chk({q_tag[1], "/R10 data"}, dq_b, last_val);
        q_kind[1] = q_kind[0]; q_val[1] = q_val[0]; q_tag[1] = q_tag[0];
        q_tag[0] = tag;
        q_val[0] = '0;
        pend = 1'b0;
        if (!s) q_kind[0] = 0;
        else if (w) begin
            q_kind[0] = 2;
            ref_mem[a] = merge(ref_mem[a], d, m);
            pend = 1'b1;
            pend_d = d;
        end else begin
            q_kind[0] = 1;
            q_val[0] = ref_mem[a];
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [3:0] m, input logic [35:0] d,
                      input string tag);
        step(1'b1, 1'b1, a, m, d, 1'b1, tag);
    endtask

    task automatic rd(input logic [5:0] a, input string tag);
        step(1'b1, 1'b0, a, 4'h0, 36'h0, 1'b1, tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 1'b0, 6'h0, 4'h0, 36'h0, 1'b1, tag);
    endtask

    function automatic logic [35:0] rnd36();
        return {$urandom, $urandom};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 64; i++) ref_mem[i] = '0;
        q_val[0] = '0; q_val[1] = '0;
        // R9: reset state
        repeat (3) @(negedge clk);
        oe = 1'b1;
        #1;
        chk("R9 oe", {35'b0, oe_a}, 36'h0);
        chk("R9 data", {18'b0, dq_a}, 36'h0);
        chk("R9/R10 data", dq_b, 36'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // fill the 16 addresses used below, then read them back (R1)
        for (int i = 0; i < 16; i++) wr(6'(i), 4'hF, rnd36(), "R7");
        for (int i = 0; i < 16; i++) rd(6'(i), "R1");

        // R2: late data, committed without forwarding
        wr(6'd3, 4'hF, 36'h1_2345_6789, "R7");
        idle("R6"); idle("R6");
        rd(6'd3, "R2");

        // R3: partial masks, including an empty one
        wr(6'd5, 4'b0101, 36'hA_BCDE_F012, "R7");
        idle("R6"); idle("R6");
        rd(6'd5, "R3");
        wr(6'd5, 4'b0000, 36'hF_FFFF_FFFF, "R7");
        idle("R6"); idle("R6");
        rd(6'd5, "R3");
        wr(6'd6, 4'b1000, 36'h5_5555_5555, "R7");
        idle("R6"); idle("R6");
        rd(6'd6, "R3");

        // R4: read immediately after write, same and different address
        wr(6'd7, 4'b1010, 36'h9_8765_4321, "R7");
        rd(6'd7, "R4");
        wr(6'd8, 4'hF, 36'h0_1111_2222, "R7");
        rd(6'd9, "R4");
        rd(6'd8, "R4");

        // R5: back-to-back writes, then same address twice in a row
        wr(6'd10, 4'hF, rnd36(), "R7");
        wr(6'd11, 4'hF, rnd36(), "R7");
        wr(6'd12, 4'hF, rnd36(), "R7");
        rd(6'd10, "R5"); rd(6'd11, "R5"); rd(6'd12, "R5");
        wr(6'd13, 4'b0011, 36'h3_3333_3333, "R7");
        wr(6'd13, 4'b0110, 36'hC_CCCC_CCCC, "R7");
        rd(6'd13, "R5");
        idle("R6"); idle("R6");
        rd(6'd13, "R5");

        // R6: deselected write attempt changes nothing
        rd(6'd1, "R1");
        step(1'b0, 1'b1, 6'd1, 4'hF, 36'hF_0F0F_0F0F, 1'b1, "R6");
        idle("R6");
        idle("R6");
        rd(6'd1, "R6");
        idle("R6"); idle("R6");

        // R8: output enable acts without a clock edge
        rd(6'd2, "R1");
        idle("R6");
        idle("R6");
        rd(6'd2, "R1");
        idle("R6");
        @(negedge clk);
        #1;
        chk("R8 on", {35'b0, oe_a}, 36'h1);
        #1 oe = 1'b0;
        #1;
        chk("R8 off", {35'b0, oe_a}, 36'h0);
        chk("R8/R10 off", {35'b0, oe_b}, 36'h0);
        #1 oe = 1'b1;
        #1;
        chk("R8 back on", {35'b0, oe_b}, 36'h1);
        // keep the record pipeline aligned: the idle above was consumed by this cycle
        q_kind[1] = q_kind[0]; q_val[1] = q_val[0]; q_tag[1] = q_tag[0];
        q_kind[0] = 0; q_tag[0] = "R6";
        pend = 1'b0;

        // constrained random traffic on 16 addresses
        for (int n = 0; n < 4000; n++) begin
            logic s, w, o;
            logic [5:0] a;
            s = ($urandom % 8) != 0;
            w = $urandom % 2;
            o = ($urandom % 8) != 0;
            a = 6'($urandom % 16);
            step(s, w, a, 4'($urandom), rnd36(), o,
                 !s ? "R6" : (w ? "R7" : "R1"));
        end
        idle("R6"); idle("R6"); idle("R6");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule